// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Router

This block collects interrupt requests for a small group of processors and turns them into priority levels from 1 to 15. System sources form one shared pending word. Each of its bits maps to a level through a table that is loaded at reset. Bits covered by a disable mask are dropped. The highest remaining level goes to one processor, which a target register selects.

Each processor also owns a private pending word. Software sets and clears the upper half of that word through a small write port. Local device events set or clear one low bit, chosen by the level of the source. A private word is delivered only to its own processor.

A processor gets a new request only when it has none outstanding. The request is a one-cycle strobe that carries a level. The processor clears its outstanding state with an acknowledge. A delivery also wakes a processor that was put into the halted state, and the block then gives a one-cycle wake pulse.

Top module: `mir_router`

## Requirements
- R1: The system pending word is `sys_irq_i` OR the internal global word. Bits set in the disable mask are ignored. The system level is the largest table level among the remaining bits. Table entries hold `i mod 16` by default, so bits 0 and 16 map to level 0 and never raise a request.
- R2: The system level goes only to the processor whose index is in the target register (write op 1). If the target is NCPU or above, no processor receives it. The target register resets to 0.
- R3: Write op 2 (set) ORs `wr_data_i & 0xFFFE0000` into the private word of processor `wr_cpu_i`. Write op 3 (clear) clears the same masked bits. Bits 16..0 of the write data have no effect.
- R4: A private word's level is the largest k in 1..15 for which bit k or bit k+16 is set.
- R5: A local event (`loc_valid_i`) for processor n looks up level p from the table entry of `loc_src_i`. If `loc_on_i` is 1 it sets bit p of processor n's private word, and if 0 it clears that bit. An event whose level is 0 is ignored.
- R6: A local event whose processor index is all ones sets or clears bit `loc_src_i` of the global word instead.
- R7: A processor with a request outstanding receives no new request. Its `ack_i` clears the outstanding state. `req_o` is a one-cycle strobe, and `lvl_o` holds a nonzero level while it is high. A nonzero system level takes precedence over the private level.
- R8: `halt_i` sets a processor's halted flag. A delivery clears that flag, and if the flag was set, `wake_o` pulses together with `req_o`.
- R9: A request appears on the first clock edge at which the pending state and `sys_irq_i` give a nonzero level to a processor that has no request outstanding. A register write or local event takes effect at its own edge, so the request follows one edge later.
- R10: After reset, `req_o`, `wake_o`, `halted_o` and `lvl_o` are all zero, the disable mask is zero and the target is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sys_irq_i | input | NSRC | System interrupt levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 2 | 0 mask, 1 target, 2 set private, 3 clear private |
| wr_cpu_i | input | CIW | Processor selected by ops 2 and 3 |
| wr_data_i | input | 32 | Write data |
| loc_valid_i | input | 1 | Local event strobe |
| loc_cpu_i | input | CIW | Local event processor index (all ones = global) |
| loc_src_i | input | SIW | Local event source number |
| loc_on_i | input | 1 | 1 asserts, 0 deasserts |
| ack_i | input | NCPU | Per-processor request acknowledge |
| halt_i | input | NCPU | Per-processor halt request |
| req_o | output | NCPU | Request strobes |
| lvl_o | output | NCPU*4 | Delivered level, 4 bits per processor |
| wake_o | output | NCPU | Wake pulses |
| halted_o | output | NCPU | Halted flags |

## Verification
On every cycle, the assertions check that each request is a single-cycle strobe with a nonzero level. They also check that no second request comes before an acknowledge, that wake pulses occur only with a request from the halted state, and that a halt request leaves the processor halted unless a delivery occurs at the same edge. Only the bench scenarios can show which level is chosen. They cover masking, table mapping, target selection and the out-of-range target, the set and clear bit masks, the merging of local and software bits, redirection of the all-ones index, and precedence of system over private levels.

// File: rtl/mir_pkg.sv
package mir_pkg;
   localparam int LVLW   = 4;
   localparam int MAXLVL = 15;
   localparam int WORDW  = 32;
   localparam logic [WORDW-1:0] SOFT_KEEP = 32'hFFFE_0000;

   typedef enum logic [1:0] {
      WR_MASK     = 2'd0,
      WR_TARGET   = 2'd1,
      WR_SOFT_SET = 2'd2,
      WR_SOFT_CLR = 2'd3
   } wr_op_e;

   function automatic logic [WORDW*LVLW-1:0] default_level_map();
      logic [WORDW*LVLW-1:0] m;
      m = '0;
      for (int i = 0; i < WORDW; i++) m[i*LVLW +: LVLW] = LVLW'(i % 16);
      return m;
   endfunction

   function automatic logic [LVLW-1:0] priv_level(input logic [WORDW-1:0] w);
      logic [LVLW-1:0] l;
      l = '0;
      for (int k = 1; k <= MAXLVL; k++)
         if (w[k] || w[k+16]) l = LVLW'(k);
      return l;
   endfunction
endpackage

// File: rtl/mir_sys_eval.sv
module mir_sys_eval #(
   parameter int NSRC = 32,
   parameter int LVLW = 4
) (
   input  logic [NSRC-1:0]           pend_i,
   input  logic [NSRC-1:0]           mask_i,
   input  logic [NSRC-1:0][LVLW-1:0] tbl_i,
   output logic [LVLW-1:0]           lvl_o
);
   logic [NSRC-1:0] live;
   assign live = pend_i & ~mask_i;

   always_comb begin
      lvl_o = '0;
      for (int i = 0; i < NSRC; i++)
         if (live[i] && tbl_i[i] > lvl_o) lvl_o = tbl_i[i];
   end
endmodule

// File: rtl/mir_cpu_slot.sv
module mir_cpu_slot
   import mir_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVLW-1:0]  sys_lvl_i,
   input  logic             soft_set_i,
   input  logic             soft_clr_i,
   input  logic [WORDW-1:0] wr_data_i,
   input  logic             loc_hit_i,
   input  logic [LVLW-1:0]  loc_bit_i,
   input  logic             loc_on_i,
   input  logic             ack_i,
   input  logic             halt_i,
   output logic             req_o,
   output logic [LVLW-1:0]  lvl_o,
   output logic             wake_o,
   output logic             halted_o
);
   logic [WORDW-1:0] priv_q, priv_d;
   logic [LVLW-1:0]  priv_lvl, pick;
   logic             busy_q, deliver;

   always_comb begin
      priv_d = priv_q;
      if (soft_set_i) priv_d = priv_d | (wr_data_i & SOFT_KEEP);
      if (soft_clr_i) priv_d = priv_d & ~(wr_data_i & SOFT_KEEP);
      if (loc_hit_i)  priv_d[loc_bit_i] = loc_on_i;
   end

   assign priv_lvl = priv_level(priv_q);
   assign pick     = (sys_lvl_i != '0) ? sys_lvl_i : priv_lvl;
   assign deliver  = !busy_q && (pick != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_q   <= '0;
         busy_q   <= 1'b0;
         req_o    <= 1'b0;
         lvl_o    <= '0;
         wake_o   <= 1'b0;
         halted_o <= 1'b0;
      end else begin
         priv_q <= priv_d;
         req_o  <= deliver;
         wake_o <= deliver && halted_o;
         if (deliver) begin
            lvl_o    <= pick;
            busy_q   <= 1'b1;
            halted_o <= 1'b0;
         end else begin
            if (ack_i)  busy_q   <= 1'b0;
            if (halt_i) halted_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/mir_router.sv
module mir_router
   import mir_pkg::*;
#(
   parameter int NCPU     = 4,
   parameter int NSRC     = 32,
   parameter int CIW      = 5,
   parameter bit SYNC_SRC = 1'b0,
   parameter logic [WORDW*LVLW-1:0] LEVEL_MAP = default_level_map(),
   localparam int SIW     = $clog2(NSRC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC-1:0]      sys_irq_i,
   input  logic                 wr_en_i,
   input  logic [1:0]           wr_op_i,
   input  logic [CIW-1:0]       wr_cpu_i,
   input  logic [WORDW-1:0]     wr_data_i,
   input  logic                 loc_valid_i,
   input  logic [CIW-1:0]       loc_cpu_i,
   input  logic [SIW-1:0]       loc_src_i,
   input  logic                 loc_on_i,
   input  logic [NCPU-1:0]      ack_i,
   input  logic [NCPU-1:0]      halt_i,
   output logic [NCPU-1:0]      req_o,
   output logic [NCPU*LVLW-1:0] lvl_o,
   output logic [NCPU-1:0]      wake_o,
   output logic [NCPU-1:0]      halted_o
);
   if (NCPU < 1 || NCPU > 16) begin : g_bad_ncpu
      $error("mir_router: NCPU must be 1..16");
   end
   if (NSRC < 2 || NSRC > WORDW) begin : g_bad_nsrc
      $error("mir_router: NSRC must be 2..32");
   end
   if (NCPU >= (1 << CIW) - 1) begin : g_bad_ciw
      $error("mir_router: CIW too narrow, all-ones index must not be a processor");
   end

   localparam logic [CIW-1:0] ALL_CPUS = '1;

   logic [NSRC-1:0][LVLW-1:0] tbl_q;
   logic [NSRC-1:0]           mask_q, gword_q, sys_eff, gpend;
   logic [CIW-1:0]            tgt_q;
   logic [LVLW-1:0]           sys_lvl, loc_lvl;
   logic                      tgt_ok, loc_glob, wr_set, wr_clr;

   // source path variant
   if (SYNC_SRC) begin : g_sync
      logic [NSRC-1:0] sys_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sys_q <= '0;
         else        sys_q <= sys_irq_i;
      assign sys_eff = sys_q;
   end else begin : g_comb
      assign sys_eff = sys_irq_i;
   end

   assign loc_glob = loc_valid_i && (loc_cpu_i == ALL_CPUS);
   assign loc_lvl  = tbl_q[loc_src_i];
   assign wr_set   = wr_en_i && (wr_op_i == WR_SOFT_SET);
   assign wr_clr   = wr_en_i && (wr_op_i == WR_SOFT_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSRC; i++) tbl_q[i] <= LEVEL_MAP[i*LVLW +: LVLW];
         mask_q  <= '0;
         tgt_q   <= '0;
         gword_q <= '0;
      end else begin
         if (wr_en_i && wr_op_i == WR_MASK)   mask_q <= wr_data_i[NSRC-1:0];
         if (wr_en_i && wr_op_i == WR_TARGET) tgt_q  <= wr_data_i[CIW-1:0];
         if (loc_glob && (int'(loc_src_i) < NSRC)) gword_q[loc_src_i] <= loc_on_i;
      end
   end

   assign gpend  = sys_eff | gword_q;
   assign tgt_ok = int'(tgt_q) < NCPU;

   mir_sys_eval #(.NSRC(NSRC), .LVLW(LVLW)) sys_eval_i (
      .pend_i (gpend),
      .mask_i (mask_q),
      .tbl_i  (tbl_q),
      .lvl_o  (sys_lvl)
   );

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic [LVLW-1:0] lvl_c, sys_c;
      logic            hit_c;
      assign sys_c = (tgt_ok && tgt_q == CIW'(c)) ? sys_lvl : '0;
      assign hit_c = loc_valid_i && !loc_glob && (loc_cpu_i == CIW'(c)) && (loc_lvl != '0);

      mir_cpu_slot slot_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .sys_lvl_i  (sys_c),
         .soft_set_i (wr_set && wr_cpu_i == CIW'(c)),
         .soft_clr_i (wr_clr && wr_cpu_i == CIW'(c)),
         .wr_data_i  (wr_data_i),
         .loc_hit_i  (hit_c),
         .loc_bit_i  (loc_lvl),
         .loc_on_i   (loc_on_i),
         .ack_i      (ack_i[c]),
         .halt_i     (halt_i[c]),
         .req_o      (req_o[c]),
         .lvl_o      (lvl_c),
         .wake_o     (wake_o[c]),
         .halted_o   (halted_o[c])
      );
      assign lvl_o[c*LVLW +: LVLW] = lvl_c;
   end
endmodule

// File: rtl/mir_router_chk.sv
module mir_router_chk #(
   parameter int NCPU = 4,
   parameter int LVLW = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NCPU-1:0]      req_o,
   input logic [NCPU*LVLW-1:0] lvl_o,
   input logic [NCPU-1:0]      wake_o,
   input logic [NCPU-1:0]      halted_o,
   input logic [NCPU-1:0]      ack_i,
   input logic [NCPU-1:0]      halt_i
);
   logic [NCPU-1:0] await_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) await_q <= '0;
      else        await_q <= (await_q | req_o) & ~ack_i;

   for (genvar c = 0; c < NCPU; c++) begin : g_a
      p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
         req_o[c] |=> !req_o[c]);
      p_level_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
         req_o[c] |-> (lvl_o[c*LVLW +: LVLW] != '0));
      p_no_req_unacked_r7: assert property (@(posedge clk) disable iff (!rst_n)
         req_o[c] |-> !await_q[c]);
      p_wake_with_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
         wake_o[c] |-> req_o[c] && !halted_o[c]);
      p_wake_from_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
         wake_o[c] |-> $past(halted_o[c]));
      p_halt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
         halt_i[c] |=> halted_o[c] || req_o[c]);
   end
endmodule

bind mir_router mir_router_chk #(.NCPU(NCPU), .LVLW(4)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_o    (req_o),
   .lvl_o    (lvl_o),
   .wake_o   (wake_o),
   .halted_o (halted_o),
   .ack_i    (ack_i),
   .halt_i   (halt_i)
);

// File: tb/mir_router_tb_top.sv
module mir_router_tb_top;
   localparam int NCPU = 4;
   localparam int NSRC = 32;
   localparam int CIW  = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NSRC-1:0] sys_irq_i = '0;
   logic wr_en_i = 1'b0;
   logic [1:0] wr_op_i = '0;
   logic [CIW-1:0] wr_cpu_i = '0;
   logic [31:0] wr_data_i = '0;
   logic loc_valid_i = 1'b0, loc_on_i = 1'b0;
   logic [CIW-1:0] loc_cpu_i = '0;
   logic [4:0] loc_src_i = '0;
   logic [NCPU-1:0] ack_i = '0, halt_i = '0;
   logic [NCPU-1:0] req_o, wake_o, halted_o;
   logic [NCPU*4-1:0] lvl_o;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mir_router dut_i (.*);

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // exp_lvl < 0 : expect no request on cpu c
   task automatic chk_cpu(input int c, input int exp_lvl, input string tag);
      if (exp_lvl < 0) chk(req_o[c] == 1'b0, tag, int'(req_o[c]), 0);
      else begin
         chk(req_o[c] == 1'b1, tag, int'(req_o[c]), 1);
         chk(int'(lvl_o[c*4 +: 4]) == exp_lvl, tag, int'(lvl_o[c*4 +: 4]), exp_lvl);
      end
   endtask

   task automatic chk_quiet(input string tag);
      chk(req_o == '0, tag, int'(req_o), 0);
   endtask

   task automatic wr(input logic [1:0] op, input int cpu, input logic [31:0] d);
      wr_en_i = 1'b1; wr_op_i = op; wr_cpu_i = CIW'(cpu); wr_data_i = d;
      tick();
      wr_en_i = 1'b0;
   endtask

   task automatic loc(input int cpu, input int src, input bit on);
      loc_valid_i = 1'b1; loc_cpu_i = CIW'(cpu); loc_src_i = 5'(src); loc_on_i = on;
      tick();
      loc_valid_i = 1'b0;
   endtask

   task automatic ack(input int c);
      ack_i[c] = 1'b1; tick(); ack_i[c] = 1'b0;
   endtask

   task automatic clean();
      sys_irq_i = '0;
      for (int c = 0; c < NCPU; c++) wr(2'd3, c, 32'hFFFF_FFFF);
      tick();
      ack_i = '1; tick(); ack_i = '0;
      tick();
   endtask

   task automatic t_reset();
      chk_quiet("R10 reset req");
      chk(wake_o == '0, "R10 reset wake", int'(wake_o), 0);
      chk(halted_o == '0, "R10 reset halted", int'(halted_o), 0);
      chk(lvl_o == '0, "R10 reset lvl", int'(lvl_o), 0);
   endtask

   task automatic t_system();
      sys_irq_i = (32'd1 << 5) | (32'd1 << 20);
      tick();
      chk_cpu(0, 5, "R1 R2 R9 max level to cpu0");
      chk_cpu(1, -1, "R2 other cpu quiet");
      tick();
      chk_cpu(0, -1, "R7 strobe one cycle");
      tick();
      chk_cpu(0, -1, "R7 no redelivery before ack");
      ack(0);
      chk_cpu(0, -1, "R7 ack edge");
      tick();
      chk_cpu(0, 5, "R7 redelivery after ack");
      clean();
   endtask

   task automatic t_mask();
      wr(2'd0, 0, 32'h8000_0000);
      sys_irq_i = (32'd1 << 31) | (32'd1 << 5);
      tick();
      chk_cpu(0, 5, "R1 masked bit ignored");
      clean();
      wr(2'd0, 0, 32'h0);
      sys_irq_i = 32'd1 << 16;
      tick(); tick();
      chk_cpu(0, -1, "R1 level-0 source");
      clean();
   endtask

   task automatic t_target();
      wr(2'd1, 0, 32'd2);
      sys_irq_i = 32'd1 << 7;
      tick();
      chk_cpu(2, 7, "R2 target cpu2");
      chk_cpu(0, -1, "R2 cpu0 not target");
      clean();
      wr(2'd1, 0, 32'd9);
      sys_irq_i = 32'd1 << 7;
      tick(); tick();
      chk_quiet("R2 absent target");
      clean();
      wr(2'd1, 0, 32'd0);
   endtask

   task automatic t_soft();
      wr(2'd2, 1, 32'hFFFF_FFFF);
      tick();
      chk_cpu(1, 15, "R3 softint set");
      wr(2'd3, 1, 32'h8000_0000);
      ack(1);
      tick();
      chk_cpu(1, 14, "R3 softint clear");
      clean();
      wr(2'd2, 3, 32'h0001_FFFF);
      tick(); tick();
      chk_cpu(3, -1, "R3 low bits dropped");
      clean();
   endtask

   task automatic t_local();
      loc(3, 9, 1'b1);
      tick();
      chk_cpu(3, 9, "R5 local assert");
      loc(3, 9, 1'b0);
      ack(3);
      tick(); tick();
      chk_cpu(3, -1, "R5 local deassert");
      loc(3, 16, 1'b1);
      tick(); tick();
      chk_cpu(3, -1, "R5 level-0 local ignored");
      // local bit 3 and softint bit 22 (level 6) together
      loc_valid_i = 1'b1; loc_cpu_i = 5'd0; loc_src_i = 5'd3; loc_on_i = 1'b1;
      wr_en_i = 1'b1; wr_op_i = 2'd2; wr_cpu_i = 5'd0; wr_data_i = 32'd1 << 22;
      tick();
      loc_valid_i = 1'b0; wr_en_i = 1'b0;
      tick();
      chk_cpu(0, 6, "R4 private max of local and soft");
      loc(0, 3, 1'b0);
      clean();
   endtask

   task automatic t_global_local();
      loc(31, 12, 1'b1);
      tick();
      chk_cpu(0, 12, "R6 all-ones goes global");
      chk_cpu(3, -1, "R6 not private");
      loc(31, 12, 1'b0);
      clean();
      chk_quiet("R6 global cleared");
   endtask

   task automatic t_prec();
      wr(2'd2, 0, 32'd1 << 30);
      tick();
      chk_cpu(0, 14, "R7 private first");
      sys_irq_i = 32'd1 << 3;
      ack(0);
      tick();
      chk_cpu(0, 3, "R7 system precedence");
      sys_irq_i = '0;
      ack(0);
      tick();
      chk_cpu(0, 14, "R7 private after system");
      clean();
   endtask

   task automatic t_wake();
      halt_i[2] = 1'b1; tick(); halt_i[2] = 1'b0;
      chk(halted_o[2] == 1'b1, "R8 halt sets", int'(halted_o[2]), 1);
      chk(wake_o[2] == 1'b0, "R8 no wake yet", int'(wake_o[2]), 0);
      wr(2'd2, 2, 32'd1 << 25);
      tick();
      chk_cpu(2, 9, "R8 delivery to halted");
      chk(wake_o[2] == 1'b1, "R8 wake pulse", int'(wake_o[2]), 1);
      chk(halted_o[2] == 1'b0, "R8 halted cleared", int'(halted_o[2]), 0);
      clean();
      wr(2'd2, 2, 32'd1 << 25);
      tick();
      chk_cpu(2, 9, "R8 delivery running");
      chk(wake_o[2] == 1'b0, "R8 no wake when running", int'(wake_o[2]), 0);
      clean();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_system();
      t_mask();
      t_target();
      t_soft();
      t_local();
      t_global_local();
      t_prec();
      t_wake();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule